// File: doc/BRIEF.md
# Wakeup and reset cause recorder

This block sits beside a power sequencer and keeps track of the events that end a low-power period or force a reset. A raw wakeup vector is masked by a per-source enable. The survivors are accumulated into a sticky wakeup-info vector, but only while the slow domain reports that it is in its low-power state. They are accumulated only while capture is armed. Capture arms when the fast domain drops its active indicator and stays armed until software writes the capture control bit to zero. Events that arrive while peripherals are still being set up after a wake are therefore not lost.

Peripheral reset requests are masked by their own enable vector and merged with an escalation reset that no mask can remove. A two-bit cause code remembers whether the most recent reset started because of low-power entry or because of a reset request. A one-cycle write port programs the enables and the control bits, and clears recorded wakeups.

Top module: `wake_rst_recorder`

## Requirements
- R1: After a synchronous reset, with all inputs low, `wake_info_o` is 0, `wake_irq_o` is 0, `rst_cause_o` is 0 and `rst_req_o` is 0. Both enable vectors reset to 0. The control register resets to capture enabled (bit 0 = 1) and interrupt disabled (bit 1 = 0).
- R2: A wakeup bit is added to `wake_info_o` only at a clock edge where capture is armed, `slow_lp_i` is 1, the raw bit is 1 and its enable bit is 1. The bit appears after that edge. While `slow_lp_i` is 0, no bit is added.
- R3: Capture arms at the first edge where `fast_active_i` is 0 after being 1 at the previous edge, provided the capture bit is 1. Wakeups presented at that edge or earlier are not recorded.
- R4: Once armed, capture stays armed through later changes of `fast_active_i` and `slow_lp_i`. A write of the control register with bit 0 = 0 disarms it. Writing bit 0 back to 1 does not rearm it before the next active-to-inactive transition.
- R5: Recorded bits are sticky. A write with select 3 clears the bits set in `wr_data_i`. A bit newly recorded at the same edge remains set.
- R6: `wake_irq_o` is registered. It equals the interrupt enable (control bit 1) AND the OR of recorded bits whose wakeup enable is set, with one cycle of delay. It first rises one cycle after the first enabled wakeup appears in `wake_info_o`.
- R7: `rst_req_o[NUM_RST-1:0]` combinationally equals the raw reset requests ANDed with the reset enable (select 1). `rst_req_o[NUM_RST]` follows `esc_rst_i` regardless of any enable.
- R8: `rst_cause_o` becomes 2 (reset request) after an edge where `rst_req_o` goes from all-zero to non-zero. It becomes 1 (low-power entry) after an edge where `slow_lp_i` rises with no such request start; the request wins if both occur. Otherwise it holds. Write selects: 0 wakeup enable, 1 reset enable, 2 control, 3 wakeup clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wake_raw_i | input | NUM_WAKE | Raw wakeup events |
| rst_raw_i | input | NUM_RST | Raw peripheral reset requests |
| esc_rst_i | input | 1 | Escalation reset, never masked |
| slow_lp_i | input | 1 | Slow domain is in low power |
| fast_active_i | input | 1 | Fast domain is active |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 wake enable, 1 reset enable, 2 control, 3 clear |
| wr_data_i | input | DATA_W | Write data |
| wake_info_o | output | NUM_WAKE | Recorded wakeup sources |
| wake_irq_o | output | 1 | Wakeup interrupt |
| rst_req_o | output | NUM_RST+1 | Masked reset requests, escalation on top bit |
| rst_cause_o | output | 2 | 0 none, 1 low-power entry, 2 reset request |

## Verification
The bench aims wakeups at the edge where the fast domain leaves active and at the edge just before it. A design that arms capture too early would record an event that should be dropped. The bench disables capture and re-enables it without a new transition; a design that rearms on the write alone would keep recording. It clears a bit in the same cycle a new event for it arrives, which a design with the wrong priority would lose. It also starts a reset request and a slow-domain rise together, so a wrong priority shows up as cause 1 instead of 2. Escalation is raised with every reset enable at zero, so a design that masks it drops the top request bit.

// File: rtl/wrr_pkg.sv
package wrr_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_LOWPWR = 2'd1,
        CAUSE_RSTREQ = 2'd2
    } cause_e;

    typedef enum logic [1:0] {
        SEL_WAKE_EN = 2'd0,
        SEL_RST_EN  = 2'd1,
        SEL_CTRL    = 2'd2,
        SEL_CLR     = 2'd3
    } wsel_e;

    localparam int CTRL_CAP_BIT = 0;
    localparam int CTRL_IRQ_BIT = 1;

    typedef struct packed {
        logic irq_en;
        logic cap_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{irq_en: 1'b0, cap_en: 1'b1};

    function automatic cause_e next_cause(cause_e cur, logic req_start, logic lp_start);
        if (req_start)     return CAUSE_RSTREQ;
        else if (lp_start) return CAUSE_LOWPWR;
        else               return cur;
    endfunction

endpackage

// File: rtl/wrr_cfg_regs.sv
module wrr_cfg_regs
    import wrr_pkg::*;
#(
    parameter int NUM_WAKE = 6,
    parameter int NUM_RST  = 3,
    parameter int DATA_W   = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_sel_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic [NUM_WAKE-1:0] wake_en_o,
    output logic [NUM_RST-1:0]  rst_en_o,
    output ctrl_t               ctrl_o,
    output logic                cap_off_o,
    output logic [NUM_WAKE-1:0] clr_mask_o
);

    logic sel_wake, sel_rst, sel_ctrl, sel_clr;

    always_comb begin
        sel_wake = wr_en_i && (wr_sel_i == SEL_WAKE_EN);
        sel_rst  = wr_en_i && (wr_sel_i == SEL_RST_EN);
        sel_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL);
        sel_clr  = wr_en_i && (wr_sel_i == SEL_CLR);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wake_en_o <= '0;
            rst_en_o  <= '0;
            ctrl_o    <= CTRL_RESET;
        end else begin
            if (sel_wake) wake_en_o <= wr_data_i[NUM_WAKE-1:0];
            if (sel_rst)  rst_en_o  <= wr_data_i[NUM_RST-1:0];
            if (sel_ctrl) begin
                ctrl_o.cap_en <= wr_data_i[CTRL_CAP_BIT];
                ctrl_o.irq_en <= wr_data_i[CTRL_IRQ_BIT];
            end
        end
    end

    assign cap_off_o  = sel_ctrl && !wr_data_i[CTRL_CAP_BIT];
    assign clr_mask_o = sel_clr ? wr_data_i[NUM_WAKE-1:0] : '0;

endmodule

// File: rtl/wrr_wake_capture.sv
module wrr_wake_capture
    import wrr_pkg::*;
#(
    parameter int NUM_WAKE = 6
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [NUM_WAKE-1:0] wake_raw_i,
    input  logic [NUM_WAKE-1:0] wake_en_i,
    input  ctrl_t               ctrl_i,
    input  logic                cap_off_i,
    input  logic [NUM_WAKE-1:0] clr_mask_i,
    input  logic                slow_lp_i,
    input  logic                fast_active_i,
    output logic [NUM_WAKE-1:0] wake_info_o,
    output logic                wake_irq_o,
    output logic                armed_o
);

    logic                fast_active_q;
    logic                leave_active;
    logic [NUM_WAKE-1:0] new_events;

    assign leave_active = fast_active_q && !fast_active_i;

    always_comb begin
        new_events = '0;
        if (armed_o && slow_lp_i) new_events = wake_raw_i & wake_en_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fast_active_q <= 1'b0;
            armed_o       <= 1'b0;
            wake_info_o   <= '0;
            wake_irq_o    <= 1'b0;
        end else begin
            fast_active_q <= fast_active_i;
            if (cap_off_i)                         armed_o <= 1'b0;
            else if (leave_active && ctrl_i.cap_en) armed_o <= 1'b1;
            wake_info_o <= (wake_info_o & ~clr_mask_i) | new_events;
            wake_irq_o  <= ctrl_i.irq_en && |(wake_info_o & wake_en_i);
        end
    end

endmodule

// File: rtl/wrr_reset_combine.sv
module wrr_reset_combine
    import wrr_pkg::*;
#(
    parameter int NUM_RST = 3
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_RST-1:0] rst_raw_i,
    input  logic [NUM_RST-1:0] rst_en_i,
    input  logic               esc_rst_i,
    input  logic               slow_lp_i,
    output logic [NUM_RST:0]   rst_req_o,
    output cause_e             cause_o
);

    logic req_any, req_any_q, slow_lp_q;

    for (genvar i = 0; i < NUM_RST; i++) begin : g_mask
        assign rst_req_o[i] = rst_raw_i[i] & rst_en_i[i];
    end
    assign rst_req_o[NUM_RST] = esc_rst_i;

    assign req_any = |rst_req_o;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            req_any_q <= 1'b0;
            slow_lp_q <= 1'b0;
            cause_o   <= CAUSE_NONE;
        end else begin
            req_any_q <= req_any;
            slow_lp_q <= slow_lp_i;
            cause_o   <= next_cause(cause_o, req_any && !req_any_q, slow_lp_i && !slow_lp_q);
        end
    end

endmodule

// File: rtl/wake_rst_recorder.sv
module wake_rst_recorder
    import wrr_pkg::*;
#(
    parameter int NUM_WAKE = 6,
    parameter int NUM_RST  = 3,
    parameter int DATA_W   = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [NUM_WAKE-1:0] wake_raw_i,
    input  logic [NUM_RST-1:0]  rst_raw_i,
    input  logic                esc_rst_i,
    input  logic                slow_lp_i,
    input  logic                fast_active_i,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_sel_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic [NUM_WAKE-1:0] wake_info_o,
    output logic                wake_irq_o,
    output logic [NUM_RST:0]    rst_req_o,
    output logic [1:0]          rst_cause_o
);

    logic [NUM_WAKE-1:0] wake_en;
    logic [NUM_RST-1:0]  rst_en;
    ctrl_t               ctrl;
    logic                cap_off;
    logic [NUM_WAKE-1:0] clr_mask;
    logic                armed;
    cause_e              cause;

    wrr_cfg_regs #(.NUM_WAKE(NUM_WAKE), .NUM_RST(NUM_RST), .DATA_W(DATA_W)) cfg_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .wake_en_o  (wake_en),
        .rst_en_o   (rst_en),
        .ctrl_o     (ctrl),
        .cap_off_o  (cap_off),
        .clr_mask_o (clr_mask)
    );

    wrr_wake_capture #(.NUM_WAKE(NUM_WAKE)) cap_i (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .wake_raw_i    (wake_raw_i),
        .wake_en_i     (wake_en),
        .ctrl_i        (ctrl),
        .cap_off_i     (cap_off),
        .clr_mask_i    (clr_mask),
        .slow_lp_i     (slow_lp_i),
        .fast_active_i (fast_active_i),
        .wake_info_o   (wake_info_o),
        .wake_irq_o    (wake_irq_o),
        .armed_o       (armed)
    );

    wrr_reset_combine #(.NUM_RST(NUM_RST)) rc_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .rst_raw_i (rst_raw_i),
        .rst_en_i  (rst_en),
        .esc_rst_i (esc_rst_i),
        .slow_lp_i (slow_lp_i),
        .rst_req_o (rst_req_o),
        .cause_o   (cause)
    );

    assign rst_cause_o = cause;

endmodule

// File: rtl/wrr_checker.sv
module wrr_checker #(
    parameter int NUM_WAKE = 6,
    parameter int NUM_RST  = 3
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                slow_lp_i,
    input logic                esc_rst_i,
    input logic                cap_off,
    input logic                armed,
    input logic [NUM_WAKE-1:0] clr_mask,
    input logic [NUM_WAKE-1:0] wake_info_o,
    input logic                wake_irq_o,
    input logic [NUM_RST-1:0]  rst_en,
    input logic [NUM_RST:0]    rst_req_o,
    input logic [1:0]          rst_cause_o
);

    // R2
    no_record_outside_lp_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !slow_lp_i |=> ((wake_info_o & ~$past(wake_info_o)) == '0));

    // R5
    sticky_info_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_mask == '0) |=> ((wake_info_o & $past(wake_info_o)) == $past(wake_info_o)));

    // R4
    disarm_only_on_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(armed) |-> $past(cap_off));

    // R6
    irq_after_info_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(wake_irq_o) |-> ($past(wake_info_o) != '0));

    // R7
    masked_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rst_req_o[NUM_RST-1:0] & ~rst_en) == '0);

    // R7
    esc_unmasked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        esc_rst_i |-> rst_req_o[NUM_RST]);

    // R8
    cause_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rst_cause_o != 2'd0) |=> (rst_cause_o != 2'd0));

    // R8
    cause_legal_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_cause_o != 2'd3);

endmodule

bind wake_rst_recorder wrr_checker #(.NUM_WAKE(NUM_WAKE), .NUM_RST(NUM_RST)) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .slow_lp_i   (slow_lp_i),
    .esc_rst_i   (esc_rst_i),
    .cap_off     (cap_off),
    .armed       (armed),
    .clr_mask    (clr_mask),
    .wake_info_o (wake_info_o),
    .wake_irq_o  (wake_irq_o),
    .rst_en      (rst_en),
    .rst_req_o   (rst_req_o),
    .rst_cause_o (rst_cause_o)
);

// File: tb/wake_rst_recorder_tb_top.sv
module wake_rst_recorder_tb_top;

    localparam int NW = 6;
    localparam int NR = 3;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [NW-1:0] wake_raw;
    logic [NR-1:0] rst_raw;
    logic          esc;
    logic          slow_lp;
    logic          fast_active;
    logic          wr_en;
    logic [1:0]    wr_sel;
    logic [DW-1:0] wr_data;
    logic [NW-1:0] wake_info;
    logic          wake_irq;
    logic [NR:0]   rst_req;
    logic [1:0]    rst_cause;

    int n_vec  = 0;
    int n_fail = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    wake_rst_recorder #(.NUM_WAKE(NW), .NUM_RST(NR), .DATA_W(DW)) dut_i (
        .clk_i(clk), .rst_i(rst), .wake_raw_i(wake_raw), .rst_raw_i(rst_raw),
        .esc_rst_i(esc), .slow_lp_i(slow_lp), .fast_active_i(fast_active),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .wake_info_o(wake_info), .wake_irq_o(wake_irq),
        .rst_req_o(rst_req), .rst_cause_o(rst_cause)
    );

    // expected-state model
    logic [NW-1:0] m_wen, m_info;
    logic [NR-1:0] m_ren;
    logic          m_cap, m_ien, m_rec, m_irq, m_fa, m_sl, m_any;
    logic [1:0]    m_cause;

    function automatic logic [NR:0] exp_req(logic [NR-1:0] raw, logic [NR-1:0] en, logic e);
        return {e, raw & en};
    endfunction

    function automatic logic [1:0] exp_cause(logic [1:0] cur, logic rs, logic ls);
        if (rs) return 2'd2;
        if (ls) return 2'd1;
        return cur;
    endfunction

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        logic [NW-1:0] n_info;
        logic          n_irq, n_rec, any;
        logic [NR:0]   req;
        logic [1:0]    n_cause;
        #1;
        req = exp_req(rst_raw, m_ren, esc);
        if (!rst) chk("rst_req (R7)", 8'(rst_req), 8'(req));
        any     = |req;
        n_info  = (m_info & ~((wr_en && wr_sel == 2'd3) ? wr_data[NW-1:0] : '0))
                | ((m_rec && slow_lp) ? (wake_raw & m_wen) : '0);
        n_irq   = m_ien && |(m_info & m_wen);
        n_rec   = (wr_en && wr_sel == 2'd2 && !wr_data[0]) ? 1'b0 :
                  (m_fa && !fast_active && m_cap) ? 1'b1 : m_rec;
        n_cause = exp_cause(m_cause, any && !m_any, slow_lp && !m_sl);
        @(posedge clk);
        if (rst) begin
            m_wen = '0; m_ren = '0; m_cap = 1'b1; m_ien = 1'b0; m_rec = 1'b0;
            m_info = '0; m_irq = 1'b0; m_fa = 1'b0; m_sl = 1'b0; m_any = 1'b0;
            m_cause = 2'd0;
        end else begin
            if (wr_en && wr_sel == 2'd0) m_wen = wr_data[NW-1:0];
            if (wr_en && wr_sel == 2'd1) m_ren = wr_data[NR-1:0];
            if (wr_en && wr_sel == 2'd2) begin m_cap = wr_data[0]; m_ien = wr_data[1]; end
            m_info = n_info; m_irq = n_irq; m_rec = n_rec; m_cause = n_cause;
            m_fa = fast_active; m_sl = slow_lp; m_any = any;
        end
        #1;
        chk("wake_info (R2)", 8'(wake_info), 8'(m_info));
        chk("wake_irq (R6)", 8'(wake_irq), 8'(m_irq));
        chk("rst_cause (R8)", 8'(rst_cause), 8'(m_cause));
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(logic [1:0] s, logic [DW-1:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        step();
    endtask

    initial begin : watchdog
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd1234));
        rst = 1'b1; wake_raw = '0; rst_raw = '0; esc = 1'b0; slow_lp = 1'b0;
        fast_active = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;
        // R1: reset state
        tag = "R1";
        step();
        chk("rst_req reset (R1)", 8'(rst_req), 8'h0);
        chk("wake_info reset (R1)", 8'(wake_info), 8'h0);

        // R3: not armed before leaving active
        tag = "R3";
        wr(2'd0, 8'h3f);
        wr(2'd2, 8'h03);
        fast_active = 1'b1; step();
        slow_lp = 1'b1; wake_raw = 6'h01; step();
        chk("no early capture (R3)", 8'(wake_info), 8'h00);
        fast_active = 1'b0; wake_raw = 6'h02; step();   // arming edge, not recorded
        chk("arming edge ignored (R3)", 8'(wake_info), 8'h00);
        wake_raw = 6'h04; step();
        chk("first capture (R3)", 8'(wake_info), 8'h04);
        // R6: irq one cycle later
        tag = "R6";
        wake_raw = '0; step();
        chk("irq raised (R6)", 8'(wake_irq), 8'h1);

        // R5: clear with simultaneous new event
        tag = "R5";
        wake_raw = 6'h04; wr(2'd3, 8'h04);
        chk("set wins over clear (R5)", 8'(wake_info), 8'h04);
        wake_raw = '0; wr(2'd3, 8'h3f);
        chk("cleared (R5)", 8'(wake_info), 8'h00);

        // R4: stays armed through active, disarm and no rearm
        tag = "R4";
        fast_active = 1'b1; slow_lp = 1'b0; step();
        slow_lp = 1'b1; wake_raw = 6'h08; step();
        chk("still armed (R4)", 8'(wake_info), 8'h08);
        wake_raw = '0;
        wr(2'd2, 8'h02);
        wr(2'd2, 8'h03);
        wake_raw = 6'h10; step(); step();
        chk("no rearm by write (R4)", 8'(wake_info), 8'h08);
        wake_raw = '0;
        wr(2'd3, 8'h3f);

        // R2: enable mask and slow lp gating
        tag = "R2";
        fast_active = 1'b0; step();
        wr(2'd0, 8'h01);
        wake_raw = 6'h3e; step();
        chk("masked sources (R2)", 8'(wake_info), 8'h00);
        slow_lp = 1'b0; wake_raw = 6'h01; step();
        chk("outside low power (R2)", 8'(wake_info), 8'h00);
        wake_raw = '0;

        // R7: escalation with zero enables; masking
        tag = "R7";
        rst_raw = 3'b111; esc = 1'b1; step();
        chk("esc only (R7)", 8'(rst_req), 8'h08);
        // R8: cause from request
        tag = "R8";
        chk("cause request (R8)", 8'(rst_cause), 8'h2);
        esc = 1'b0; rst_raw = '0; step();
        slow_lp = 1'b1; step();
        chk("cause lowpower (R8)", 8'(rst_cause), 8'h1);
        slow_lp = 1'b0; step();
        wr(2'd1, 8'h05);
        slow_lp = 1'b1; rst_raw = 3'b101; step();
        chk("request wins (R8)", 8'(rst_cause), 8'h2);
        rst_raw = '0; step();

        // random phase
        tag = "R2";
        for (int i = 0; i < 3000; i++) begin
            wake_raw = NW'($urandom);
            rst_raw  = ($urandom % 4 == 0) ? NR'($urandom) : '0;
            esc      = ($urandom % 40 == 0);
            if ($urandom % 10 == 0) slow_lp = ~slow_lp;
            if ($urandom % 12 == 0) fast_active = ~fast_active;
            if ($urandom % 6 == 0) begin
                wr_en   = 1'b1;
                wr_sel  = 2'($urandom);
                wr_data = DW'($urandom);
                if (wr_sel == 2'd2 && ($urandom % 4 != 0)) wr_data[0] = 1'b1;
            end
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule